// File: doc/BRIEF.md
# PCI Boot Resource Allocator

This block runs a single pass over a table of up to `NUM_DEV` PCI functions, starting by itself as soon as reset is released. For each present device it enables I/O and memory decoding by writing back the command word with its two low bits set. It then visits the device's BAR slots one per clock and gives every unassigned I/O BAR a base address. I/O space is packed from 0x1000 upward and stops at a hard ceiling. Last, it gives the device an interrupt line if the device asks for one.

The device table is kept outside the block. The allocator presents a device index and a BAR index, and the table answers on the same cycle with the command word, device number, interrupt field and the BAR's size, address and I/O flag. Results leave through a registered write port that carries one write per cycle. Each write has a kind code, a device index, a BAR index and a data word. Placement failures are kept as sticky per-BAR flags. The level-trigger mask is valid once the single-cycle done pulse appears.

Interrupts are assigned in one of two ways. With the advanced interrupt controller, a device's line follows from its device number. In legacy mode, lines are handed out round-robin over an allowed set. Each legacy line that is handed out is also recorded in the level-trigger mask.

Top module: `pci_boot_alloc`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_en`, `done`, `lvl_mask`, `err_io_full` and `err_mem_bar` are all zero.
- R2: For each device whose `tbl_present` is 1, the first write is kind 0 (command) with data equal to `tbl_cmd | 0x0003`. This write comes before any write for that device's BARs. A device whose `tbl_present` is 0 produces no writes.
- R3: An I/O BAR is unassigned when its size is nonzero and its address is zero. Each unassigned I/O BAR gets a kind 1 write whose data is the current I/O pointer. The pointer starts at 0x1000 and goes up by the BAR size after each placement. BARs are visited in device order and then in BAR order.
- R4: A BAR whose size is zero, or whose address is already nonzero, produces no write and raises no flag.
- R5: If pointer + size is 0x10000 or more, the BAR gets no write and bit `dev*NUM_BAR+bar` of `err_io_full` is set. The pointer does not change, and later BARs are still placed.
- R6: An unassigned memory BAR (`tbl_bar_io`=0) gets no write and sets bit `dev*NUM_BAR+bar` of `err_mem_bar`.
- R7: When `adv_irq_mode`=1, a device whose interrupt field is 0x00 gets a kind 2 write with data 16 + (device number mod 4).
- R8: When `adv_irq_mode`=0, a device whose interrupt field is 0x00 gets a kind 2 write. Its data is the first line in the set {5,7,9,10,11}, searching upward modulo 16 from the line given previously. The search starts after line 0.
- R9: A device whose interrupt field is nonzero, including 0xFF (no interrupt wanted), gets no kind 2 write and adds no bit to the mask.
- R10: When done is high, `lvl_mask` is the OR of `1 << line` over every legacy line handed out in the pass, including the last device's line. In advanced mode it is 0.
- R11: `done` is high for exactly one cycle. It appears in the same cycle as the last device's interrupt write, if that write exists. No write follows it until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the pass starts after release |
| adv_irq_mode | input | 1 | 1 = advanced interrupt controller present, 0 = legacy lines |
| tbl_dev | output | DEV_W | Device index being looked up |
| tbl_bar | output | BAR_W | BAR slot being looked up |
| tbl_present | input | 1 | Table entry holds a device |
| tbl_cmd | input | 16 | Current command word of the device |
| tbl_devnum | input | 5 | PCI device number of the entry |
| tbl_irq | input | 8 | Interrupt field: 0x00 = needs one, other = keep |
| tbl_bar_size | input | ADDR_W | Size of the addressed BAR, 0 = slot unused |
| tbl_bar_addr | input | ADDR_W | Address already held by the BAR |
| tbl_bar_io | input | 1 | 1 = I/O BAR, 0 = memory BAR |
| wr_en | output | 1 | Write-back strobe |
| wr_kind | output | 2 | 0 = command, 1 = BAR address, 2 = interrupt line |
| wr_dev | output | DEV_W | Device index of the write |
| wr_bar | output | BAR_W | BAR slot of a kind 1 write |
| wr_data | output | ADDR_W | Value written |
| err_io_full | output | NUM_DEV*NUM_BAR | Sticky flags: I/O BAR did not fit below the ceiling |
| err_mem_bar | output | NUM_DEV*NUM_BAR | Sticky flags: memory BAR left unassigned |
| lvl_mask | output | 16 | Level-trigger line mask, valid with done |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The last device's interrupt assignment and the end-of-pass report happen in the same clock. At that edge the done pulse, the final kind 2 write and the level mask update all land together. A dedicated pass makes only the last table entry ask for a legacy line. At the sample where done is high, the bench requires that write to be present with line 5 and the mask to already hold bit 5. A mask that lags by a cycle, or a done that comes early or late, is reported.

// File: rtl/pba_pkg.sv
package pba_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_BAR,
    ST_IRQ,
    ST_END
  } pba_state_e;

  localparam logic [1:0] WK_CMD = 2'd0;
  localparam logic [1:0] WK_BAR = 2'd1;
  localparam logic [1:0] WK_IRQ = 2'd2;

  // First allowed line strictly after prev, wrapping modulo 16; prev itself last.
  function automatic logic [3:0] pba_next_line(input logic [3:0] prev,
                                               input logic [15:0] allowed);
    logic [3:0] cand;
    pba_next_line = prev;
    for (int k = 16; k >= 1; k--) begin
      cand = prev + 4'(k);
      if (allowed[cand]) pba_next_line = cand;
    end
  endfunction

endpackage

// File: rtl/pba_io_packer.sv
module pba_io_packer #(
  parameter int ADDR_W = 32,
  parameter longint unsigned IO_START = 64'h1000,
  parameter longint unsigned IO_CEIL  = 64'h10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              try_en,
  input  logic [ADDR_W-1:0] size,
  output logic [ADDR_W-1:0] base,
  output logic              fits
);

  localparam logic [ADDR_W:0]   CEIL_X  = (ADDR_W+1)'(IO_CEIL);
  localparam logic [ADDR_W-1:0] START_X = ADDR_W'(IO_START);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W:0]   sum;

  assign sum  = {1'b0, ptr_q} + {1'b0, size};
  assign fits = (sum < CEIL_X);
  assign base = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= START_X;
    end else if (try_en && fits) begin
      ptr_q <= sum[ADDR_W-1:0];
    end
  end

  AST_PTR_BELOW_CEIL: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, ptr_q} < CEIL_X)); // R5

  AST_PTR_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ptr_q >= $past(ptr_q))); // R3

  AST_PTR_HOLD_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    (try_en && !fits) |=> $stable(ptr_q)); // R5

endmodule

// File: rtl/pba_irq_picker.sv
module pba_irq_picker
  import pba_pkg::*;
#(
  parameter logic [15:0] ALLOWED     = 16'h0EA0,
  parameter int          APIC_BASE   = 16,
  parameter int          APIC_SPREAD = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  logic        adv_mode,
  input  logic [4:0]  devnum,
  output logic [7:0]  line,
  output logic [15:0] used,
  output logic [15:0] used_next
);

  logic [3:0]  prev_q;
  logic [15:0] used_q;
  logic [3:0]  leg_line;
  logic [7:0]  adv_line;

  assign leg_line = pba_next_line(prev_q, ALLOWED);

  generate
    if ((APIC_SPREAD & (APIC_SPREAD - 1)) == 0) begin : g_pow2
      assign adv_line = 8'(APIC_BASE) + 8'(devnum & 5'(APIC_SPREAD - 1));
    end else begin : g_mod
      assign adv_line = 8'(APIC_BASE + (int'(devnum) % APIC_SPREAD));
    end
  endgenerate

  assign line      = adv_mode ? adv_line : {4'd0, leg_line};
  assign used      = used_q;
  assign used_next = used_q | ((take && !adv_mode) ? (16'd1 << leg_line) : 16'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 4'd0;
      used_q <= 16'd0;
    end else if (take && !adv_mode) begin
      prev_q <= leg_line;
      used_q <= used_next;
    end
  end

  AST_USED_IN_ALLOWED: assert property (@(posedge clk) disable iff (rst)
    ((used_q & ~ALLOWED) == 16'd0)); // R8

  AST_LEGACY_LINE_ALLOWED: assert property (@(posedge clk) disable iff (rst)
    (take && !adv_mode) |-> ALLOWED[leg_line]); // R8

  AST_ADV_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (take && adv_mode) |-> (line >= 8'(APIC_BASE))); // R7

endmodule

// File: rtl/pci_boot_alloc.sv
module pci_boot_alloc
  import pba_pkg::*;
#(
  parameter int              NUM_DEV     = 8,
  parameter int              NUM_BAR     = 6,
  parameter int              ADDR_W      = 32,
  parameter longint unsigned IO_START    = 64'h1000,
  parameter longint unsigned IO_CEIL     = 64'h10000,
  parameter logic [15:0]     IRQ_ALLOWED = 16'h0EA0,
  parameter int              APIC_BASE   = 16,
  parameter int              APIC_SPREAD = 4,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int BAR_W  = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1,
  localparam int FLAGS  = NUM_DEV * NUM_BAR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_irq_mode,
  output logic [DEV_W-1:0]  tbl_dev,
  output logic [BAR_W-1:0]  tbl_bar,
  input  logic              tbl_present,
  input  logic [15:0]       tbl_cmd,
  input  logic [4:0]        tbl_devnum,
  input  logic [7:0]        tbl_irq,
  input  logic [ADDR_W-1:0] tbl_bar_size,
  input  logic [ADDR_W-1:0] tbl_bar_addr,
  input  logic              tbl_bar_io,
  output logic              wr_en,
  output logic [1:0]        wr_kind,
  output logic [DEV_W-1:0]  wr_dev,
  output logic [BAR_W-1:0]  wr_bar,
  output logic [ADDR_W-1:0] wr_data,
  output logic [FLAGS-1:0]  err_io_full,
  output logic [FLAGS-1:0]  err_mem_bar,
  output logic [15:0]       lvl_mask,
  output logic              done
);

  localparam int FLAG_W = (FLAGS > 1) ? $clog2(FLAGS) : 1;
  localparam logic [DEV_W-1:0] LAST_DEV = DEV_W'(NUM_DEV - 1);
  localparam logic [BAR_W-1:0] LAST_BAR = BAR_W'(NUM_BAR - 1);

  pba_state_e        state_q;
  logic [DEV_W-1:0]  dev_q;
  logic [BAR_W-1:0]  bar_q;
  logic [FLAGS-1:0]  err_io_q, err_mem_q;
  logic [FLAG_W-1:0] flag_idx;
  logic              bar_open, io_try, irq_take, last_dev;
  logic [ADDR_W-1:0] io_base;
  logic              io_fits;
  logic [7:0]        irq_line;
  logic [15:0]       used_mask, used_next;

  assign tbl_dev     = dev_q;
  assign tbl_bar     = bar_q;
  assign err_io_full = err_io_q;
  assign err_mem_bar = err_mem_q;

  assign last_dev = (dev_q == LAST_DEV);
  assign flag_idx = FLAG_W'(int'(dev_q) * NUM_BAR + int'(bar_q));
  assign bar_open = (tbl_bar_size != '0) && (tbl_bar_addr == '0);
  assign io_try   = (state_q == ST_BAR) && bar_open && tbl_bar_io;
  assign irq_take = (state_q == ST_IRQ) && (tbl_irq == 8'h00);

  pba_io_packer #(
    .ADDR_W   (ADDR_W),
    .IO_START (IO_START),
    .IO_CEIL  (IO_CEIL)
  ) u_packer (
    .clk    (clk),
    .rst    (rst),
    .try_en (io_try),
    .size   (tbl_bar_size),
    .base   (io_base),
    .fits   (io_fits)
  );

  pba_irq_picker #(
    .ALLOWED     (IRQ_ALLOWED),
    .APIC_BASE   (APIC_BASE),
    .APIC_SPREAD (APIC_SPREAD)
  ) u_picker (
    .clk       (clk),
    .rst       (rst),
    .take      (irq_take),
    .adv_mode  (adv_irq_mode),
    .devnum    (tbl_devnum),
    .line      (irq_line),
    .used      (used_mask),
    .used_next (used_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      dev_q     <= '0;
      bar_q     <= '0;
      wr_en     <= 1'b0;
      wr_kind   <= WK_CMD;
      wr_dev    <= '0;
      wr_bar    <= '0;
      wr_data   <= '0;
      err_io_q  <= '0;
      err_mem_q <= '0;
      lvl_mask  <= 16'd0;
      done      <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          dev_q   <= '0;
          state_q <= ST_CMD;
        end
        ST_CMD: begin
          if (tbl_present) begin
            wr_en   <= 1'b1;
            wr_kind <= WK_CMD;
            wr_dev  <= dev_q;
            wr_bar  <= '0;
            wr_data <= ADDR_W'(tbl_cmd | 16'h0003);
            bar_q   <= '0;
            state_q <= ST_BAR;
          end else if (last_dev) begin
            done     <= 1'b1;
            lvl_mask <= adv_irq_mode ? 16'd0 : used_mask;
            state_q  <= ST_END;
          end else begin
            dev_q <= dev_q + 1'b1;
          end
        end
        ST_BAR: begin
          if (bar_open) begin
            if (!tbl_bar_io) begin
              err_mem_q[flag_idx] <= 1'b1;
            end else if (io_fits) begin
              wr_en   <= 1'b1;
              wr_kind <= WK_BAR;
              wr_dev  <= dev_q;
              wr_bar  <= bar_q;
              wr_data <= io_base;
            end else begin
              err_io_q[flag_idx] <= 1'b1;
            end
          end
          if (bar_q == LAST_BAR) state_q <= ST_IRQ;
          else                   bar_q   <= bar_q + 1'b1;
        end
        ST_IRQ: begin
          if (irq_take) begin
            wr_en   <= 1'b1;
            wr_kind <= WK_IRQ;
            wr_dev  <= dev_q;
            wr_bar  <= '0;
            wr_data <= ADDR_W'(irq_line);
          end
          if (last_dev) begin
            done     <= 1'b1;
            lvl_mask <= adv_irq_mode ? 16'd0 : used_next;
            state_q  <= ST_END;
          end else begin
            dev_q   <= dev_q + 1'b1;
            state_q <= ST_CMD;
          end
        end
        default: state_q <= ST_END;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_END) |=> !wr_en); // R11

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    ((err_io_q & err_mem_q) == '0)); // R6

  AST_BAR_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == WK_BAR) |-> (wr_data >= ADDR_W'(IO_START))); // R3

endmodule

// File: tb/pci_boot_alloc_tb.sv
module pci_boot_alloc_tb;

  localparam int ND = 6;
  localparam int NB = 3;
  localparam int AW = 32;
  localparam int FL = ND * NB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv_mode = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]    tbl_dev;
  logic [1:0]    tbl_bar;
  logic          tbl_present;
  logic [15:0]   tbl_cmd;
  logic [4:0]    tbl_devnum;
  logic [7:0]    tbl_irq;
  logic [AW-1:0] tbl_bar_size, tbl_bar_addr;
  logic          tbl_bar_io;
  logic          wr_en;
  logic [1:0]    wr_kind;
  logic [2:0]    wr_dev;
  logic [1:0]    wr_bar;
  logic [AW-1:0] wr_data;
  logic [FL-1:0] err_io_full, err_mem_bar;
  logic [15:0]   lvl_mask;
  logic          done;

  logic          t_present [8];
  logic [15:0]   t_cmd     [8];
  logic [4:0]    t_num     [8];
  logic [7:0]    t_irq     [8];
  logic [AW-1:0] t_size    [8][4];
  logic [AW-1:0] t_addr    [8][4];
  logic          t_io      [8][4];

  always_comb begin
    tbl_present  = t_present[tbl_dev];
    tbl_cmd      = t_cmd[tbl_dev];
    tbl_devnum   = t_num[tbl_dev];
    tbl_irq      = t_irq[tbl_dev];
    tbl_bar_size = t_size[tbl_dev][tbl_bar];
    tbl_bar_addr = t_addr[tbl_dev][tbl_bar];
    tbl_bar_io   = t_io[tbl_dev][tbl_bar];
  end

  pci_boot_alloc #(.NUM_DEV(ND), .NUM_BAR(NB), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .adv_irq_mode(adv_mode),
    .tbl_dev(tbl_dev), .tbl_bar(tbl_bar), .tbl_present(tbl_present),
    .tbl_cmd(tbl_cmd), .tbl_devnum(tbl_devnum), .tbl_irq(tbl_irq),
    .tbl_bar_size(tbl_bar_size), .tbl_bar_addr(tbl_bar_addr), .tbl_bar_io(tbl_bar_io),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_dev(wr_dev), .wr_bar(wr_bar), .wr_data(wr_data),
    .err_io_full(err_io_full), .err_mem_bar(err_mem_bar), .lvl_mask(lvl_mask), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Write log, sampled on the falling edge.
  logic [1:0]    lk [32];
  logic [2:0]    ld [32];
  logic [1:0]    lb [32];
  logic [AW-1:0] lv [32];
  int  n_wr, done_cnt, late_wr;
  logic saw_done, done_wr;
  logic [1:0]  done_kind;
  logic [AW-1:0] done_data;
  logic [15:0] done_mask;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en && saw_done) late_wr++;
      if (wr_en && n_wr < 32) begin
        lk[n_wr] = wr_kind; ld[n_wr] = wr_dev; lb[n_wr] = wr_bar; lv[n_wr] = wr_data;
        n_wr++;
      end
      if (done) begin
        done_cnt++;
        saw_done  = 1'b1;
        done_wr   = wr_en;
        done_kind = wr_kind;
        done_data = wr_data;
        done_mask = lvl_mask;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] find_irq(input int d);
    find_irq = 32'hFFFF_FFFF;
    for (int i = 0; i < n_wr; i++)
      if (lk[i] == 2'd2 && int'(ld[i]) == d) find_irq = lv[i];
  endfunction

  function automatic logic [AW-1:0] find_bar(input int d, input int b);
    find_bar = 32'hFFFF_FFFF;
    for (int i = 0; i < n_wr; i++)
      if (lk[i] == 2'd1 && int'(ld[i]) == d && int'(lb[i]) == b) find_bar = lv[i];
  endfunction

  task automatic clear_tbl();
    for (int d = 0; d < 8; d++) begin
      t_present[d] = 1'b0; t_cmd[d] = 16'h0; t_num[d] = 5'(d); t_irq[d] = 8'hFF;
      for (int b = 0; b < 4; b++) begin
        t_size[d][b] = '0; t_addr[d][b] = '0; t_io[d][b] = 1'b1;
      end
    end
  endtask

  task automatic run(input logic adv, input string tag);
    int cyc;
    @(negedge clk);
    adv_mode = adv;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state visible at the ports
    chk({"R1 reset wr_en ", tag}, 64'(wr_en), 64'd0);
    chk({"R1 reset done ", tag}, 64'(done), 64'd0);
    chk({"R1 reset mask ", tag}, 64'(lvl_mask), 64'd0);
    chk({"R1 reset flags ", tag}, 64'({err_io_full, err_mem_bar}), 64'd0);
    n_wr = 0; done_cnt = 0; late_wr = 0; saw_done = 1'b0; done_wr = 1'b0;
    rst = 1'b0;
    cyc = 0;
    while (!saw_done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    if (!saw_done) chk({"R11 watchdog ", tag}, 64'd0, 64'd1);
    repeat (20) @(negedge clk);
    chk({"R11 single done ", tag}, 64'(done_cnt), 64'd1);
    chk({"R11 no late write ", tag}, 64'(late_wr), 64'd0);
  endtask

  // Scenario A expected write stream: {kind, dev, bar, data}
  localparam logic [38:0] EXP_A [8] = '{
    {2'd0, 3'd0, 2'd0, 32'h0000_0007},
    {2'd1, 3'd0, 2'd0, 32'h0000_1000},
    {2'd2, 3'd0, 2'd0, 32'd5},
    {2'd0, 3'd1, 2'd0, 32'h0000_0003},
    {2'd1, 3'd1, 2'd1, 32'h0000_1100},
    {2'd2, 3'd1, 2'd0, 32'd7},
    {2'd0, 3'd3, 2'd0, 32'h0000_0103},
    {2'd1, 3'd3, 2'd0, 32'h0000_1140}
  };

  task automatic load_a();
    clear_tbl();
    t_present[0] = 1; t_cmd[0] = 16'h0004; t_irq[0] = 8'h00;
    t_size[0][0] = 32'h100;  t_io[0][0] = 1;
    t_size[0][1] = 32'h1000; t_io[0][1] = 0;
    t_present[1] = 1; t_irq[1] = 8'h00;
    t_size[1][0] = 32'h20; t_addr[1][0] = 32'h3000;
    t_size[1][1] = 32'h40;
    t_present[3] = 1; t_cmd[3] = 16'h0100; t_irq[3] = 8'hFF;
    t_size[3][0] = 32'h10;
  endtask

  initial begin
    // ---- Scenario A: legacy, mixed BARs, vector walk ----
    load_a();
    run(1'b0, "A");
    chk("R2 R3 R4 R9 write count A", 64'(n_wr), 64'd8);
    for (int i = 0; i < 8; i++) begin
      logic [1:0] ek; logic [2:0] ed; logic [1:0] eb; logic [31:0] ev;
      {ek, ed, eb, ev} = EXP_A[i];
      chk(ek == 2'd0 ? "R2 cmd kind" : ek == 2'd1 ? "R3 bar kind" : "R8 irq kind", 64'(lk[i]), 64'(ek));
      chk(ek == 2'd0 ? "R2 cmd dev"  : ek == 2'd1 ? "R3 bar dev"  : "R8 irq dev",  64'(ld[i]), 64'(ed));
      if (ek == 2'd1) chk("R3 bar slot", 64'(lb[i]), 64'(eb));
      chk(ek == 2'd0 ? "R2 cmd data" : ek == 2'd1 ? "R3 bar data" : "R8 irq data", 64'(lv[i]), 64'(ev));
    end
    chk("R6 mem flag A", 64'(err_mem_bar), 64'h2);
    chk("R4 io flags A", 64'(err_io_full), 64'h0);
    chk("R10 mask A", 64'(done_mask), 64'h00A0);

    // ---- Scenario B: advanced controller ----
    load_a();
    t_irq[3] = 8'h00; t_num[3] = 5'd7;
    run(1'b1, "B");
    chk("R7 adv dev0", 64'(find_irq(0)), 64'd16);
    chk("R7 adv dev1", 64'(find_irq(1)), 64'd17);
    chk("R7 adv dev3", 64'(find_irq(3)), 64'd19);
    chk("R10 adv mask", 64'(done_mask), 64'h0);
    chk("R2 absent dev2", 64'(find_irq(2)), 64'hFFFF_FFFF);

    // ---- Scenario C: ceiling and legacy wrap ----
    clear_tbl();
    for (int d = 0; d < ND; d++) begin t_present[d] = 1; t_irq[d] = 8'h00; end
    t_size[0][0] = 32'hE000; t_size[0][1] = 32'h1000; t_size[0][2] = 32'h0FFF;
    t_size[1][0] = 32'h1;
    run(1'b0, "C");
    chk("R3 first fill", 64'(find_bar(0, 0)), 64'h1000);
    chk("R5 overflow no write", 64'(find_bar(0, 1)), 64'hFFFF_FFFF);
    chk("R5 continue after miss", 64'(find_bar(0, 2)), 64'hF000);
    chk("R5 exact ceiling miss", 64'(find_bar(1, 0)), 64'hFFFF_FFFF);
    chk("R5 overflow flags", 64'(err_io_full), 64'h0000A);
    chk("R8 rr dev0", 64'(find_irq(0)), 64'd5);
    chk("R8 rr dev1", 64'(find_irq(1)), 64'd7);
    chk("R8 rr dev2", 64'(find_irq(2)), 64'd9);
    chk("R8 rr dev3", 64'(find_irq(3)), 64'd10);
    chk("R8 rr dev4", 64'(find_irq(4)), 64'd11);
    chk("R8 rr wrap dev5", 64'(find_irq(5)), 64'd5);
    chk("R10 full mask", 64'(done_mask), 64'h0EA0);

    // ---- Scenario D: done coincides with last interrupt write ----
    clear_tbl();
    t_present[0] = 1; t_irq[0] = 8'hFF;
    t_present[1] = 1; t_irq[1] = 8'hFF;
    t_present[2] = 1; t_irq[2] = 8'h03;
    t_present[3] = 1; t_irq[3] = 8'h03;
    t_present[5] = 1; t_irq[5] = 8'h00;
    run(1'b0, "D");
    chk("R9 no irq write skipped", 64'(find_irq(2)), 64'hFFFF_FFFF);
    chk("R9 no irq write 0xFF", 64'(find_irq(0)), 64'hFFFF_FFFF);
    chk("R11 write with done", 64'(done_wr), 64'd1);
    chk("R11 kind with done", 64'(done_kind), 64'd2);
    chk("R8 line with done", 64'(done_data), 64'd5);
    chk("R10 mask with done", 64'(done_mask), 64'h0020);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL R11 global watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule